// File: doc/BRIEF.md
# Multi-Lane Serial Audio Receiver

This block turns serial audio on up to three data lanes into signed parallel samples. The lanes share one bit clock and one word clock. The word clock's level tells the left half-frame from the right half-frame. The block either follows bit and word clocks from an external source (slave), or makes both clocks itself from its own system clock (master). Three framings are supported: standard I2S, where the MSB comes one bit clock after the word-clock edge; left-justified, where the MSB comes on the edge; and right-justified, where the word fills the tail of its half-frame. Sample words are 16, 24 or 32 bits long and are always delivered sign-extended to 32 bits.

A four-state controller is shared by all lanes. The states are IDLE, SEEK, LEFT and RIGHT.
- IDLE→SEEK: the global enable rises.
- SEEK→LEFT: the first effective word-clock boundary into the left channel.
- LEFT→RIGHT and RIGHT→LEFT: every later effective boundary.
- Any state→IDLE: the global enable falls.

The effective boundary is the word-clock change itself for the justified framings. For I2S it is one sampling edge later. At each boundary that ends a LEFT or RIGHT half, every enabled lane delivers the word it captured in that half. Each lane has a single output register with a take handshake and a sticky overrun flag.

Top module: `i2s_rx`

## Requirements
- R1: `wlen_sel` sets the word length: 0 gives 16 bits, 1 gives 24 bits, 2 or 3 gives 32 bits. Each delivered word is the captured N bits, received MSB first and sign-extended to 32 bits.
- R2: `fmt_sel` sets the framing:
  - 0 (I2S): the MSB is the bit sampled one edge after the word-clock change.
  - 1 (left-justified): the MSB is the bit sampled at the change.
  - 2 (right-justified): the word is the last N bits of the half-frame.
  - 3: treated as 1.
- R3: In slave mode, data and word clock are sampled on the rising bit-clock edge when `bclk_inv`=0, and on the falling edge when `bclk_inv`=1.
- R4: With `ws_inv`=0 a low word clock marks the left channel; with `ws_inv`=1 a high word clock does. `word_right_o` is 0 for a left word and 1 for a right word.
- R5: After the global enable rises, all bits before the first boundary into the left channel are discarded. The first word delivered is therefore a left word.
- R6: A word is delivered at the effective boundary that ends its half-frame, as a one-cycle `word_vld_o` pulse. If fewer than N bits were sampled in that half-frame, the word is dropped.
- R7: A lane delivers words only while both `glb_en` and its `lane_en` bit are high.
- R8: A word that arrives while the lane still holds an untaken word overwrites the register and sets `overrun_o`. `take_i` high in a cycle clears the held flag. The overrun flag stays set until `glb_en` goes low.
- R9: In master mode (`master_en`=1, `glb_en`=1):
  - `bclk_o` runs at clk/2 (`div4_sel`=0) or clk/4 (`div4_sel`=1).
  - `ws_o` toggles every 16, 32 or 64 bit clocks for `frame_sel` 0, 1 or 2.
  - `ws_o` starts at the left level.
  - When master mode is off, both clock outputs are 0.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the master clock source |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global receive enable |
| lane_en | input | NLANES | Per-lane enable |
| master_en | input | 1 | 1: generate clocks, 0: follow external clocks |
| div4_sel | input | 1 | Master bit-clock divider: 0 gives /2, 1 gives /4 |
| frame_sel | input | 2 | Master frame length: 0 = 32, 1 = 64, 2 = 128 bit clocks |
| fmt_sel | input | 2 | Framing: 0 = I2S, 1 = left-justified, 2 = right-justified |
| wlen_sel | input | 2 | Word length: 0 = 16, 1 = 24, 2 = 32 bits |
| bclk_inv | input | 1 | Selects the sampling bit-clock edge |
| ws_inv | input | 1 | Selects the word-clock level that marks left |
| bclk_i | input | 1 | External bit clock (slave) |
| ws_i | input | 1 | External word clock (slave) |
| sd_i | input | NLANES | Serial data, one bit per lane |
| take_i | input | NLANES | Consumer has taken the held word |
| bclk_o | output | 1 | Generated bit clock (master) |
| ws_o | output | 1 | Generated word clock (master) |
| word_o | output | 32*NLANES | Sign-extended words; lane k in bits 32k+31:32k |
| word_vld_o | output | NLANES | One-cycle pulse per delivered word |
| word_right_o | output | 1 | Channel tag of the most recent words |
| overrun_o | output | NLANES | Sticky per-lane overrun flag |

## Verification
The hardest situation to reach is bit placement at the edges of a half-frame. This covers the I2S LSB that arrives after the word clock has already changed, the right-justified word sitting behind junk padding, and a half-frame too short for the word. The bench drives the slave clocks bit by bit from a model of a transmitter. The model fills every unused slot position with junk. It sweeps all framings, word lengths and both polarities with a 32-bit slot. It also runs a deliberately short 16-bit slot and a stream that starts with a partial right half, so that both the discard and the drop rules are exercised.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int OUT_W = 32;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_ALT = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

    function automatic logic [7:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd16;
            2'd1:    return 8'd24;
            default: return 8'd32;
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] sign_ext(input logic [OUT_W-1:0] v,
                                                    input logic [1:0] code);
        case (code)
            2'd0:    return {{16{v[15]}}, v[15:0]};
            2'd1:    return {{8{v[23]}}, v[23:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
    parameter int NLANES    = 3,
    parameter int MIN_FRAME = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              div4,
    input  logic [1:0]        frame_sel,
    input  logic              bclk_inv,
    input  logic              ws_inv,
    input  logic              bclk_i,
    input  logic              ws_i,
    input  logic [NLANES-1:0] sd_i,
    output logic              stb,
    output logic              ws_smp,
    output logic [NLANES-1:0] sd_smp,
    output logic              bclk_o,
    output logic              ws_o
);
    localparam int HALF_MAX = MIN_FRAME * 2;
    localparam int FC_W     = $clog2(HALF_MAX);

    logic            run, tick, hcnt, ph, ws_r;
    logic [FC_W-1:0] fcnt, half_last;
    logic [2:0]      bsync;
    logic [1:0]      wsync;
    logic [NLANES-1:0] sd_s1, sd_s2;
    logic            smp_lvl, s_stb;

    assign run  = en && master;
    assign tick = run && (hcnt == div4);

    always_comb begin
        case (frame_sel)
            2'd0:    half_last = FC_W'(MIN_FRAME / 2 - 1);
            2'd1:    half_last = FC_W'(MIN_FRAME - 1);
            default: half_last = FC_W'(HALF_MAX - 1);
        endcase
    end

    // master clock generation: ph 0->1 is the sampling edge, 1->0 the launch edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= 1'b0;
            ph   <= 1'b0;
            ws_r <= 1'b0;
            fcnt <= '0;
        end else if (!run) begin
            hcnt <= 1'b0;
            ph   <= 1'b0;
            ws_r <= 1'b0;
            fcnt <= '0;
        end else begin
            hcnt <= tick ? 1'b0 : ~hcnt;
            if (tick) begin
                ph <= ~ph;
                if (ph) begin
                    if (fcnt == half_last) begin
                        fcnt <= '0;
                        ws_r <= ~ws_r;
                    end else begin
                        fcnt <= fcnt + 1'b1;
                    end
                end
            end
        end
    end

    // slave input synchronizers, equal depth so clocks and data stay aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsync <= '0;
            wsync <= '0;
            sd_s1 <= '0;
            sd_s2 <= '0;
        end else begin
            bsync <= {bsync[1:0], bclk_i};
            wsync <= {wsync[0], ws_i};
            sd_s1 <= sd_i;
            sd_s2 <= sd_s1;
        end
    end

    assign smp_lvl = ~bclk_inv;
    assign s_stb   = en && !master && (bsync[1] == smp_lvl) && (bsync[2] != smp_lvl);

    assign stb    = master ? (tick && !ph) : s_stb;
    assign ws_smp = master ? (ws_r ^ ws_inv) : wsync[1];
    assign sd_smp = master ? sd_i : sd_s2;
    assign bclk_o = master ? (ph ^ bclk_inv) : 1'b0;
    assign ws_o   = master ? (ws_r ^ ws_inv) : 1'b0;

    // R3: sampling strobes are never back to back
    a_r3_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R9: the generated word clock only moves on a launch edge of the bit clock
    a_r9_ws_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(ws_r)) |-> ($past(ph) && !ph));

endmodule

// File: rtl/i2s_rx_frame_fsm.sv
module i2s_rx_frame_fsm
    import i2s_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       stb,
    input  logic       ws_smp,
    input  logic       ws_inv,
    input  logic [1:0] fmt,
    input  logic [1:0] wlen,
    output logic       load,
    output logic       shift,
    output logic       emit,
    output logic       emit_right
);
    rx_state_e        state, nxt;
    logic             now, now_q, dly_q, eff_cur, eff_old, bnd, is_i2s, is_rj;
    logic [CNT_W-1:0] cnt, nbits;

    assign is_i2s  = (fmt_e'(fmt) == FMT_I2S);
    assign is_rj   = (fmt_e'(fmt) == FMT_RJ);
    assign nbits   = CNT_W'(wlen_bits(wlen));
    assign now     = ws_smp ^ ws_inv;             // 1 = right channel
    assign eff_cur = is_i2s ? now_q : now;
    assign eff_old = is_i2s ? dly_q : now_q;
    assign bnd     = stb && (eff_cur != eff_old);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q <= 1'b0;
            dly_q <= 1'b0;
            cnt   <= '0;
        end else if (!en) begin
            now_q <= 1'b0;
            dly_q <= 1'b0;
            cnt   <= '0;
        end else if (stb) begin
            now_q <= now;
            dly_q <= now_q;
            if (bnd)
                cnt <= CNT_W'(1);
            else if (cnt != {CNT_W{1'b1}})
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_SEEK;
                ST_SEEK:  if (bnd && !eff_cur) nxt = ST_LEFT;
                ST_LEFT:  if (bnd) nxt = ST_RIGHT;
                ST_RIGHT: if (bnd) nxt = ST_LEFT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load       = 1'b0;
        shift      = 1'b0;
        emit       = 1'b0;
        emit_right = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEEK: begin
                load  = bnd;
                shift = stb && !bnd;
            end
            ST_LEFT, ST_RIGHT: begin
                load       = bnd;
                shift      = stb && !bnd && (is_rj || cnt < nbits);
                emit       = bnd && (cnt >= nbits);
                emit_right = (state == ST_RIGHT);
            end
        endcase
    end

    // R7: dropping the global enable always returns the controller to IDLE
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));

    // R5: a right half can only follow a left half
    a_r5_right_after_left: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RIGHT && $past(state) != ST_RIGHT) |-> ($past(state) == ST_LEFT));

endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
    import i2s_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             lane_en,
    input  logic             load,
    input  logic             shift,
    input  logic             emit,
    input  logic             sd,
    input  logic [1:0]       wlen,
    input  logic             take,
    output logic [OUT_W-1:0] word_q,
    output logic             vld_q,
    output logic             ovr_q
);
    logic [OUT_W-1:0] sr;
    logic             full_q, new_w;

    assign new_w = emit && lane_en && en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= {{(OUT_W-1){1'b0}}, sd};
        else if (shift) sr <= {sr[OUT_W-2:0], sd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            vld_q <= new_w;
            if (new_w) begin
                word_q <= sign_ext(sr, wlen);
                full_q <= 1'b1;
            end else if (take) begin
                full_q <= 1'b0;
            end
            if (!en)
                ovr_q <= 1'b0;
            else if (new_w && full_q && !take)
                ovr_q <= 1'b1;
        end
    end

    // R6: a delivered word is flagged for exactly one cycle
    a_r6_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R7: no delivery unless both enables were high
    a_r7_vld_gated: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(en && lane_en));

    // R8: overrun holds while the global enable stays high
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && en) |=> ovr_q);

endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
    import i2s_rx_pkg::*;
#(
    parameter int NLANES    = 3,
    parameter int MIN_FRAME = 32,
    parameter int CNT_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    glb_en,
    input  logic [NLANES-1:0]       lane_en,
    input  logic                    master_en,
    input  logic                    div4_sel,
    input  logic [1:0]              frame_sel,
    input  logic [1:0]              fmt_sel,
    input  logic [1:0]              wlen_sel,
    input  logic                    bclk_inv,
    input  logic                    ws_inv,
    input  logic                    bclk_i,
    input  logic                    ws_i,
    input  logic [NLANES-1:0]       sd_i,
    input  logic [NLANES-1:0]       take_i,
    output logic                    bclk_o,
    output logic                    ws_o,
    output logic [NLANES*OUT_W-1:0] word_o,
    output logic [NLANES-1:0]       word_vld_o,
    output logic                    word_right_o,
    output logic [NLANES-1:0]       overrun_o
);
    logic              stb, ws_smp, load, shift, emit, emit_right, tag_q;
    logic [NLANES-1:0] sd_smp;

    i2s_rx_clkgen #(.NLANES(NLANES), .MIN_FRAME(MIN_FRAME)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(glb_en), .master(master_en),
        .div4(div4_sel), .frame_sel(frame_sel), .bclk_inv(bclk_inv),
        .ws_inv(ws_inv), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
        .stb(stb), .ws_smp(ws_smp), .sd_smp(sd_smp),
        .bclk_o(bclk_o), .ws_o(ws_o)
    );

    i2s_rx_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(glb_en), .stb(stb), .ws_smp(ws_smp),
        .ws_inv(ws_inv), .fmt(fmt_sel), .wlen(wlen_sel),
        .load(load), .shift(shift), .emit(emit), .emit_right(emit_right)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        i2s_rx_lane u_lane (
            .clk(clk), .rst_n(rst_n), .en(glb_en), .lane_en(lane_en[g]),
            .load(load), .shift(shift), .emit(emit), .sd(sd_smp[g]),
            .wlen(wlen_sel), .take(take_i[g]),
            .word_q(word_o[g*OUT_W +: OUT_W]), .vld_q(word_vld_o[g]),
            .ovr_q(overrun_o[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tag_q <= 1'b0;
        else if (emit) tag_q <= emit_right;
    end

    assign word_right_o = tag_q;

endmodule

// File: tb/i2s_rx_tb_top.sv
module i2s_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int HB = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic glb_en = 0, master_en = 0, div4_sel = 0, bclk_inv = 0, ws_inv = 0;
    logic bclk_i = 0, ws_i = 0;
    logic [NL-1:0] lane_en = '1, sd_i = '0, take_i = '1;
    logic [1:0] frame_sel = 0, fmt_sel = 0, wlen_sel = 0;
    logic bclk_o, ws_o, word_right_o;
    logic [NL*32-1:0] word_o;
    logic [NL-1:0] word_vld_o, overrun_o;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] cap_w [NL][512];
    logic        cap_t [NL][512];
    int          cap_n [NL];

    i2s_rx #(.NLANES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .lane_en(lane_en),
        .master_en(master_en), .div4_sel(div4_sel), .frame_sel(frame_sel),
        .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .bclk_inv(bclk_inv),
        .ws_inv(ws_inv), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
        .take_i(take_i), .bclk_o(bclk_o), .ws_o(ws_o), .word_o(word_o),
        .word_vld_o(word_vld_o), .word_right_o(word_right_o),
        .overrun_o(overrun_o)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial for (int l = 0; l < NL; l++) cap_n[l] = 0;

    always @(negedge clk) begin
        for (int l = 0; l < NL; l++) begin
            if (rst_n && word_vld_o[l] && cap_n[l] < 512) begin
                cap_w[l][cap_n[l]] = word_o[l*32 +: 32];
                cap_t[l][cap_n[l]] = word_right_o;
                cap_n[l] = cap_n[l] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] c);
        return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
    endfunction

    function automatic logic [31:0] wgen(input int lane, input int h, input int cfg);
        return 32'(32'h9E3779B9 * 32'(h + 1 + 4 * lane)) ^ 32'(cfg * 32'h01030507);
    endfunction

    function automatic logic [31:0] sx(input logic [31:0] w, input int n);
        if (n == 16) return {{16{w[15]}}, w[15:0]};
        if (n == 24) return {{8{w[23]}}, w[23:0]};
        return w;
    endfunction

    task automatic send_bit(input logic right, input logic [NL-1:0] d);
        @(negedge clk);
        bclk_i = bclk_inv;
        ws_i   = right ^ ws_inv;
        sd_i   = d;
        repeat (HB) @(negedge clk);
        bclk_i = ~bclk_inv;
        repeat (HB - 1) @(negedge clk);
    endtask

    // transmitter model: partial right half, L R L R, short left tail
    task automatic run_stream(input int S, input int cfg);
        logic [NL-1:0] prev, lj;
        int n;
        n = nb(wlen_sel);
        prev = '0;
        for (int k = 0; k < 5 + 4 * S + 3; k++) begin
            int h, p;
            logic right;
            logic [NL-1:0] junk;
            junk = NL'(k * 7 + 3);
            if (k < 5) begin
                right = 1'b1; lj = junk;
            end else if (k >= 5 + 4 * S) begin
                right = 1'b0; lj = junk;
            end else begin
                h = (k - 5) / S;
                p = (k - 5) % S;
                right = h[0];
                for (int l = 0; l < NL; l++) begin
                    logic [31:0] w;
                    w = wgen(l, h, cfg);
                    if (fmt_sel == 2'd2)
                        lj[l] = (p >= S - n) ? w[n - 1 - (p - (S - n))] : junk[l];
                    else
                        lj[l] = (p < n) ? w[n - 1 - p] : junk[l];
                end
            end
            send_bit(right, (fmt_sel == 2'd0) ? prev : lj);
            prev = lj;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic check_stream(input int cfg, input int base [NL],
                                input logic [NL-1:0] mask, input string req);
        int n;
        n = nb(wlen_sel);
        for (int l = 0; l < NL; l++) begin
            int got;
            got = cap_n[l] - base[l];
            if (!mask[l]) begin
                chk(got == 0, {req, " lane silent count"}, 32'(got), 32'd0);
            end else begin
                chk(got == 4, {req, " R5 R6 word count"}, 32'(got), 32'd4);
                for (int i = 0; i < 4 && i < got; i++) begin
                    chk(cap_w[l][base[l] + i] == sx(wgen(l, i, cfg), n),
                        {req, " R1 R2 R3 word value"}, cap_w[l][base[l] + i],
                        sx(wgen(l, i, cfg), n));
                    chk(cap_t[l][base[l] + i] == i[0], {req, " R4 channel tag"},
                        32'(cap_t[l][base[l] + i]), 32'(i[0]));
                end
            end
        end
    endtask

    task automatic restart();
        glb_en = 0;
        repeat (4) @(negedge clk);
        glb_en = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic snap(output int b [NL]);
        for (int l = 0; l < NL; l++) b[l] = cap_n[l];
    endtask

    task automatic measure(output int bper, output int whalf);
        logic pb, pw;
        int c;
        @(negedge clk); pb = bclk_o;
        c = 0;
        while (!(!pb && bclk_o) && c < 2000) begin pb = bclk_o; @(negedge clk); c++; end
        bper = 0; pb = bclk_o;
        do begin @(negedge clk); bper++; end
        while (!(!pb && bclk_o) && bper < 2000 && ((pb = bclk_o) || 1));
        pw = ws_o; c = 0;
        while (ws_o == pw && c < 4000) begin @(negedge clk); c++; end
        pw = ws_o; whalf = 0;
        while (ws_o == pw && whalf < 4000) begin @(negedge clk); whalf++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base [NL];
        int bp, wh, cfg;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(word_vld_o == 0 && overrun_o == 0, "R10 reset flags",
            32'({word_vld_o, overrun_o}), 32'd0);
        chk(word_o == 0, "R10 reset word", word_o[31:0], 32'd0);
        chk(bclk_o == 0 && ws_o == 0 && word_right_o == 0, "R10 reset clocks",
            32'({bclk_o, ws_o, word_right_o}), 32'd0);

        // sweep framing x word length x both polarities, 32-bit slots
        for (int f = 0; f < 3; f++)
            for (int w = 0; w < 3; w++)
                for (int bi = 0; bi < 2; bi++)
                    for (int wi = 0; wi < 2; wi++) begin
                        cfg = f * 12 + w * 4 + bi * 2 + wi;
                        fmt_sel = 2'(f); wlen_sel = 2'(w);
                        bclk_inv = bi[0]; ws_inv = wi[0];
                        bclk_i = bi[0];
                        restart();
                        snap(base);
                        run_stream(32, cfg);
                        check_stream(cfg, base, '1, "R2 sweep");
                        chk(bclk_o == 0 && ws_o == 0, "R9 slave clocks idle",
                            32'({bclk_o, ws_o}), 32'd0);
                    end
        chk(overrun_o == 0, "R8 no overrun when taken", 32'(overrun_o), 32'd0);

        // reserved framing code 3 behaves as left-justified, 16-bit exact slot
        fmt_sel = 2'd3; wlen_sel = 2'd0; bclk_inv = 0; ws_inv = 0; bclk_i = 0;
        restart(); snap(base);
        fmt_sel = 2'd3;
        run_stream(16, 40);
        check_stream(40, base, '1, "R2 code3 R1 16bit slot");

        // half-frame too short for the word: dropped
        fmt_sel = 2'd1; wlen_sel = 2'd1;
        restart(); snap(base);
        run_stream(16, 41);
        check_stream(41, base, '0, "R6 short slot drop");

        // word length code 3 acts as 32 bits
        wlen_sel = 2'd3;
        restart(); snap(base);
        run_stream(32, 42);
        check_stream(42, base, '1, "R1 code3");

        // lane enable gating
        wlen_sel = 2'd0; lane_en = 3'b101;
        restart(); snap(base);
        run_stream(32, 43);
        check_stream(43, base, 3'b101, "R7 lane enable");
        lane_en = '1;

        // global enable off
        glb_en = 0; snap(base);
        run_stream(32, 44);
        check_stream(44, base, '0, "R7 global off");

        // overrun: lane 0 never takes
        take_i = 3'b110;
        restart(); snap(base);
        run_stream(32, 45);
        chk(overrun_o == 3'b001, "R8 overrun set", 32'(overrun_o), 32'd1);
        chk(word_o[31:0] == sx(wgen(0, 3, 45), 16), "R8 overwrite latest",
            word_o[31:0], sx(wgen(0, 3, 45), 16));
        repeat (20) @(negedge clk);
        chk(overrun_o == 3'b001, "R8 overrun sticky", 32'(overrun_o), 32'd1);
        glb_en = 0;
        repeat (2) @(negedge clk);
        chk(overrun_o == 0, "R8 overrun cleared", 32'(overrun_o), 32'd0);
        take_i = '1;

        // master mode clock rates and reception
        master_en = 1; div4_sel = 1; frame_sel = 2'd1; fmt_sel = 2'd1;
        wlen_sel = 2'd0; sd_i = '1; bclk_inv = 0; ws_inv = 0;
        restart(); snap(base);
        chk(ws_o == 0, "R9 ws starts left", 32'(ws_o), 32'd0);
        measure(bp, wh);
        chk(bp == 4, "R9 bclk div4", 32'(bp), 32'd4);
        chk(wh == 128, "R9 ws frame64", 32'(wh), 32'd128);
        begin
            int t;
            t = 0;
            while (cap_n[0] == base[0] && t < 3000) begin @(negedge clk); t++; end
        end
        chk(cap_n[0] > base[0], "R9 master word received", 32'(cap_n[0] - base[0]), 32'd1);
        chk(cap_w[0][base[0]] == 32'hFFFF_FFFF, "R9 R1 master word value",
            cap_w[0][base[0]], 32'hFFFF_FFFF);
        chk(cap_t[0][base[0]] == 1'b0, "R9 R5 master first left",
            32'(cap_t[0][base[0]]), 32'd0);

        div4_sel = 0; frame_sel = 2'd0;
        restart();
        measure(bp, wh);
        chk(bp == 2, "R9 bclk div2", 32'(bp), 32'd2);
        chk(wh == 32, "R9 ws frame32", 32'(wh), 32'd32);

        div4_sel = 1; frame_sel = 2'd2;
        restart();
        measure(bp, wh);
        chk(wh == 256, "R9 ws frame128", 32'(wh), 32'd256);
        master_en = 0;
        @(negedge clk);
        chk(bclk_o == 0 && ws_o == 0, "R9 master off", 32'({bclk_o, ws_o}), 32'd0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule